// File: doc/BRIEF.md
# Priority Clear-Load Registered Selector

This block is a W-bit registered selector with three synchronous control levels. A clear has the highest priority and forces the register to zero. Below it, a load forces a dedicated load word into the register. When neither is active, a one-bit select chooses between a "high" word and a "low" word. Every control is sampled only at the rising clock edge, and no path leads from an input to the output without passing through the register.

A second operating mode extends the block into a six-input registered selector that keeps the clear. In this mode a combinational front selector, four words wide by default, drives the "high" leg of the two-way path. A single select code then chooses among the four front words, the low word and the load word. That code is decoded onto the internal load, pick and front-index controls. The remaining code values leave the register unchanged. A datapath uses the block where one pipeline register has to merge several sources and also needs a clean zero.

Internally a decoder turns the mode, controls and code into one enumerated command: clear, load, take-high, take-low or hold. A next-state process acts on that command with a unique case, and a separate process holds the register.

Top module: `prio_sel_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, `q` is zero after that edge, whatever the other inputs are. The reset is synchronous.
- R2: When `clr` is high at a rising edge, `q` becomes zero, whatever the values of `ld`, `sel`, `six_en` and `code`.
- R3: In basic mode (`six_en`=0), with `clr` low and `ld` high, `q` takes `d_ld`.
- R4: In basic mode, with `clr` and `ld` low, `q` takes `d_hi` when `sel`=1 and `d_lo` when `sel`=0.
- R5: In six-input mode (`six_en`=1), with `clr` low and `code` 0 to 3, `q` takes front word `code`. Front word k is `front_in[k*W +: W]`.
- R6: In six-input mode, with `clr` low, code 4 loads `d_lo` and code 5 loads `d_ld`.
- R7: In six-input mode, with `clr` low, codes 6 and 7 keep `q` at its present value over any number of edges, even while the data inputs change.
- R8: In six-input mode, `ld`, `sel` and `d_hi` have no effect on `q`.
- R9: In basic mode, `code` and `front_in` have no effect on `q`.
- R10: `q` changes only at a rising edge, and it reflects the inputs sampled at the previous edge (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| six_en | input | 1 | 0 = basic clear/load/select mode, 1 = six-input coded mode |
| clr | input | 1 | Synchronous clear, top priority in both modes |
| ld | input | 1 | Load request (basic mode only) |
| sel | input | 1 | 1 picks `d_hi`, 0 picks `d_lo` (basic mode only) |
| code | input | 3 | Six-input select code (0-3 front, 4 low, 5 load, 6-7 hold) |
| d_hi | input | W | High word for the basic two-way path |
| d_lo | input | W | Low word, used in both modes |
| d_ld | input | W | Load word, used in both modes |
| front_in | input | 4*W | Four front words packed, word k at bits k*W upward |
| q | output | W | Registered result |

## Verification
Every result is due exactly one rising edge after the inputs that produce it are applied. The bench changes inputs only on falling edges and samples `q` 1 ns after the following rising edge. To show that nothing reaches `q` early, some scenarios also sample `q` just after the new inputs are applied, before the edge, and expect the old value. For the hold codes, the bench samples across several consecutive edges while the data inputs keep changing, and expects the same value each time.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

    // Decoded per-cycle action for the result register
    typedef enum logic [2:0] {
        CMD_CLEAR,
        CMD_LOAD,
        CMD_TAKE_HI,
        CMD_TAKE_LO,
        CMD_HOLD
    } sel_cmd_e;

endpackage

// File: rtl/prio_sel_front.sv
// Combinational N:1 front selector built as a masked OR sum.
module prio_sel_front #(
    parameter int W = 32,
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0] f_in,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        y
);

    logic [N-1:0][W-1:0] masked;

    genvar g;
    for (g = 0; g < N; g++) begin : g_mask
        assign masked[g] = (idx == IW'(g)) ? f_in[g] : '0;
    end

    always_comb begin
        y = '0;
        for (int i = 0; i < N; i++) begin
            y = y | masked[i];
        end
    end

endmodule

// File: rtl/prio_sel_decode.sv
// Maps mode, controls and select code onto a single register command.
module prio_sel_decode
    import prio_sel_pkg::*;
#(
    parameter int FRONT_N = 4,
    localparam int IW     = (FRONT_N > 1) ? $clog2(FRONT_N) : 1,
    localparam int CODE_W = $clog2(FRONT_N + 2)
) (
    input  logic              six_en,
    input  logic              clr,
    input  logic              ld,
    input  logic              sel,
    input  logic [CODE_W-1:0] code,
    output sel_cmd_e          cmd,
    output logic [IW-1:0]     front_idx
);

    localparam logic [CODE_W-1:0] CODE_LO = CODE_W'(FRONT_N);
    localparam logic [CODE_W-1:0] CODE_LD = CODE_W'(FRONT_N + 1);

    always_comb begin
        front_idx = code[IW-1:0];
        if (clr) begin
            cmd = CMD_CLEAR;
        end else if (six_en) begin
            if (code < CODE_LO)       cmd = CMD_TAKE_HI;
            else if (code == CODE_LO) cmd = CMD_TAKE_LO;
            else if (code == CODE_LD) cmd = CMD_LOAD;
            else                      cmd = CMD_HOLD;
        end else if (ld) begin
            cmd = CMD_LOAD;
        end else if (sel) begin
            cmd = CMD_TAKE_HI;
        end else begin
            cmd = CMD_TAKE_LO;
        end
    end

endmodule

// File: rtl/prio_sel_core.sv
// Result register: next-state process plus state register.
module prio_sel_core
    import prio_sel_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sel_cmd_e     cmd,
    input  logic [W-1:0] hi_word,
    input  logic [W-1:0] lo_word,
    input  logic [W-1:0] ld_word,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    always_comb begin
        unique case (cmd)
            CMD_CLEAR:   q_next = '0;
            CMD_LOAD:    q_next = ld_word;
            CMD_TAKE_HI: q_next = hi_word;
            CMD_TAKE_LO: q_next = lo_word;
            CMD_HOLD:    q_next = q;
            default:     q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

endmodule

// File: rtl/prio_sel_reg.sv
// Top: priority clear/load registered selector with optional six-input mode.
module prio_sel_reg
    import prio_sel_pkg::*;
#(
    parameter int W       = 32,
    parameter int FRONT_N = 4,
    localparam int CODE_W = $clog2(FRONT_N + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 six_en,
    input  logic                 clr,
    input  logic                 ld,
    input  logic                 sel,
    input  logic [CODE_W-1:0]    code,
    input  logic [W-1:0]         d_hi,
    input  logic [W-1:0]         d_lo,
    input  logic [W-1:0]         d_ld,
    input  logic [FRONT_N*W-1:0] front_in,
    output logic [W-1:0]         q
);

    localparam int IW = (FRONT_N > 1) ? $clog2(FRONT_N) : 1;

    sel_cmd_e                  cmd;
    logic [IW-1:0]             front_idx;
    logic [FRONT_N-1:0][W-1:0] front_arr;
    logic [W-1:0]              front_y;
    logic [W-1:0]              hi_src;

    genvar k;
    for (k = 0; k < FRONT_N; k++) begin : g_unpack
        assign front_arr[k] = front_in[k*W +: W];
    end

    prio_sel_decode #(.FRONT_N(FRONT_N)) u_dec (
        .six_en    (six_en),
        .clr       (clr),
        .ld        (ld),
        .sel       (sel),
        .code      (code),
        .cmd       (cmd),
        .front_idx (front_idx)
    );

    prio_sel_front #(.W(W), .N(FRONT_N)) u_front (
        .f_in (front_arr),
        .idx  (front_idx),
        .y    (front_y)
    );

    assign hi_src = six_en ? front_y : d_hi;

    prio_sel_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .hi_word (hi_src),
        .lo_word (d_lo),
        .ld_word (d_ld),
        .q       (q)
    );

endmodule

// File: rtl/prio_sel_chk.sv
module prio_sel_chk #(
    parameter int W       = 32,
    parameter int FRONT_N = 4,
    localparam int CODE_W = $clog2(FRONT_N + 2)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 six_en,
    input logic                 clr,
    input logic                 ld,
    input logic                 sel,
    input logic [CODE_W-1:0]    code,
    input logic [W-1:0]         d_hi,
    input logic [W-1:0]         d_lo,
    input logic [W-1:0]         d_ld,
    input logic [FRONT_N*W-1:0] front_in,
    input logic [W-1:0]         q
);

    logic rst_prev;
    logic armed;

    always_ff @(posedge clk) begin
        rst_prev <= !rst_n;
        armed    <= 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (armed === 1'b1 && rst_prev === 1'b1) begin
            rst_zero_chk: assert (q == '0) else $error("R1 reset did not zero q");
        end
    end

    // R2
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);

    // R3
    basic_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!six_en && !clr && ld) |=> q == $past(d_ld));

    // R4
    basic_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!six_en && !clr && !ld && sel) |=> q == $past(d_hi));

    // R4
    basic_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!six_en && !clr && !ld && !sel) |=> q == $past(d_lo));

    // R5
    six_front_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (six_en && !clr && code == '0) |=> q == $past(front_in[W-1:0]));

    // R5
    six_front_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (six_en && !clr && code == CODE_W'(FRONT_N - 1))
        |=> q == $past(front_in[FRONT_N*W-1 -: W]));

    // R6
    six_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (six_en && !clr && code == CODE_W'(FRONT_N)) |=> q == $past(d_lo));

    // R6
    six_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (six_en && !clr && code == CODE_W'(FRONT_N + 1)) |=> q == $past(d_ld));

    // R7
    six_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (six_en && !clr && code > CODE_W'(FRONT_N + 1)) |=> $stable(q));

endmodule

bind prio_sel_reg prio_sel_chk #(.W(W), .FRONT_N(FRONT_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .six_en   (six_en),
    .clr      (clr),
    .ld       (ld),
    .sel      (sel),
    .code     (code),
    .d_hi     (d_hi),
    .d_lo     (d_lo),
    .d_ld     (d_ld),
    .front_in (front_in),
    .q        (q)
);

// File: tb/prio_sel_reg_bench.sv
`timescale 1ns/1ps
module prio_sel_reg_bench;

    localparam int W  = 32;
    localparam int FN = 4;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            six_en = 1'b0;
    logic            clr = 1'b0;
    logic            ld = 1'b0;
    logic            sel = 1'b0;
    logic [CW-1:0]   code = '0;
    logic [W-1:0]    d_hi = 32'h1111_1111;
    logic [W-1:0]    d_lo = 32'h2222_2222;
    logic [W-1:0]    d_ld = 32'h3333_3333;
    logic [FN*W-1:0] front_in = '0;
    logic [W-1:0]    q;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prio_sel_reg #(.W(W), .FRONT_N(FN)) u_prio_sel_reg (
        .clk(clk), .rst_n(rst_n), .six_en(six_en), .clr(clr), .ld(ld),
        .sel(sel), .code(code), .d_hi(d_hi), .d_lo(d_lo), .d_ld(d_ld),
        .front_in(front_in), .q(q)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(bit s6, bit c, bit l, bit s, logic [CW-1:0] k);
        @(negedge clk);
        six_en = s6; clr = c; ld = l; sel = s; code = k;
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic set_front(logic [W-1:0] base);
        for (int i = 0; i < FN; i++) front_in[i*W +: W] = base + W'(i * 32'h0101);
    endtask

    // R1: synchronous reset zeroes q, even with load requested
    task automatic t_reset;
        tick; tick;
        check("R1 initial reset", q, '0);
        drive(0, 0, 1, 0, '0); rst_n = 1'b1; d_ld = 32'hDEAD_BEEF;
        tick;
        check("R3 load after reset", q, 32'hDEAD_BEEF);
        drive(0, 0, 1, 0, '0); rst_n = 1'b0;
        tick;
        check("R1 mid-run reset", q, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // R2: clear beats load and selection in both modes
    task automatic t_clear;
        drive(0, 0, 1, 0, '0); d_ld = 32'hCAFE_0001; tick;
        drive(0, 1, 1, 1, '0); tick;
        check("R2 clr with ld and sel", q, '0);
        drive(0, 0, 1, 0, '0); d_ld = 32'hCAFE_0002; tick;
        drive(1, 1, 0, 0, 3'd5); tick;
        check("R2 clr in six mode code 5", q, '0);
        drive(1, 0, 0, 0, 3'd5); tick;
        drive(1, 1, 0, 0, 3'd7); tick;
        check("R2 clr over hold code", q, '0);
    endtask

    // R3, R4, R10: basic mode priority, selection and latency
    task automatic t_basic;
        drive(0, 0, 1, 1, '0); d_ld = 32'h0BAD_F00D; d_hi = 32'h1234_5678; tick;
        check("R3 ld beats sel", q, 32'h0BAD_F00D);
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 0, 1, '0);
            d_hi = 32'hA000_0000 ^ W'(i * 32'h0F0F);
            d_lo = 32'h5000_0000 + W'(i);
            #1;
            check("R10 no change before edge", q, (i == 0) ? 32'h0BAD_F00D : 32'h5000_0000 + W'(i - 1));
            tick;
            check("R4 sel=1 picks d_hi", q, 32'hA000_0000 ^ W'(i * 32'h0F0F));
            drive(0, 0, 0, 0, '0); tick;
            check("R4 sel=0 picks d_lo", q, 32'h5000_0000 + W'(i));
        end
    endtask

    // R9: code and front words ignored in basic mode
    task automatic t_basic_ignores;
        d_hi = 32'h7777_0000;
        for (int k = 0; k < 8; k++) begin
            drive(0, 0, 0, 1, CW'(k)); set_front(32'hF000_0000 + W'(k)); tick;
            check("R9 code/front ignored", q, 32'h7777_0000);
        end
    endtask

    // R5, R8: front words by code, ld/sel/d_hi ignored
    task automatic t_six_front;
        set_front(32'h4000_0010);
        for (int k = 0; k < FN; k++) begin
            drive(1, 0, 1, k[0], CW'(k)); d_hi = 32'hEEEE_0000 + W'(k); tick;
            check("R5 R8 front word", q, 32'h4000_0010 + W'(k * 32'h0101));
        end
    endtask

    // R6, R8: code 4 low word, code 5 load word
    task automatic t_six_pair;
        d_lo = 32'h0000_4444; d_ld = 32'h0000_5555; d_hi = 32'h9999_9999;
        drive(1, 0, 1, 1, 3'd4); tick;
        check("R6 R8 code 4 d_lo", q, 32'h0000_4444);
        drive(1, 0, 0, 1, 3'd5); tick;
        check("R6 code 5 d_ld", q, 32'h0000_5555);
    endtask

    // R7: hold codes keep q across edges while data moves
    task automatic t_six_hold;
        drive(1, 0, 0, 0, 3'd5); d_ld = 32'h600D_600D; tick;
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, i[0], i[1], (i < 2) ? 3'd6 : 3'd7);
            d_ld = W'(i); d_lo = W'(i + 9); set_front(W'(i * 7)); tick;
            check("R7 hold code", q, 32'h600D_600D);
        end
    endtask

    initial begin
        t_reset;
        t_clear;
        t_basic;
        t_basic_ignores;
        t_six_front;
        t_six_pair;
        t_six_hold;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule